// File: doc/BRIEF.md
# Operand Effective Address Generator

This block serves the operand-fetch stage of a core whose opcodes are 16 bits wide. When an instruction names a source operand, the decode stage pulses `start` for one cycle. With that pulse it supplies the addressing mode, the register number, the operand size, a flat copy of the sixteen 32-bit registers, the address of the instruction, and the first two extension words that sit in the prefetch queue. The block forms the effective address and reports any update to the base register. It then steps through a fixed list of microcycles, one per clock. Each microcycle is an idle cycle, a prefetch that consumes one extension word from the program stream, or an operand read of one 16-bit word. When the list is finished, the block presents the operand together with a single-cycle `done` pulse.

Register-direct, quick and immediate forms need no data read. Memory forms generate addresses from the register, the PC, the index register, the displacement or an absolute value. The block decodes the brief extension word itself for the indexed forms. A long operand is read as two words. Every input is captured at the accepted start, so the decode stage is free to move on as soon as the block accepts an operation.

Top module: `ea_operand_unit`

## Requirements
- R1: After reset the block is ready (`ready`=1), `bus_op` shows no operation (code 0), and `done` and `wb_valid` are both 0.
- R2: Indexed modes (`mode` 6 = register-based, 8 = PC-based) form the address as base + index + the sign-extended `ext0[7:0]`. Bits `ext0[15:12]` select the index register: values 0–7 are data registers and 8–15 are address registers. If `ext0[11]`=1 the full 32-bit index is used; if it is 0, the sign-extended low 16 bits are used.
- R3: The PC-relative forms (`mode` 7 = displacement, 8 = indexed) use `instr_addr`+2 as their base.
- R4: Mode 5 adds the sign-extended `ext0` to address register An. Mode 9 uses the sign-extended `ext0` as the address. Mode 10 uses {`ext0`,`ext1`} as the address. Mode 2 uses An as the address.
- R5: The step size is 4 for long operands (`size`=2), 2 for word (`size`=1), and 1 for byte (`size`=0), except that register 7 steps by 2 for bytes. Postincrement (mode 3) reads at the old An and writes back An+step. Predecrement (mode 4) writes back An−step and reads at that new value. The write-back appears on `wb_valid`/`wb_reg` (8+n)/`wb_value` in the first cycle after the accepted start.
- R6: The microcycle list is a fixed order of `bus_op` codes (1 = idle, 2 = prefetch, 3 = read), one per clock, starting in the first cycle after the start:
  - modes 2 and 3: reads only;
  - mode 4: one idle, then the reads;
  - modes 5, 7 and 9: one prefetch, then the reads;
  - modes 6 and 8: one idle, then one prefetch, then the reads;
  - mode 10: two prefetches, then the reads.
- R7: A long operand takes two reads: the high word at the effective address, then the low word at the effective address + 2. The operand is {high, low}. A word operand is the 16-bit read value, zero-extended. A byte operand is `bus_rdata[7:0]`, zero-extended. `bus_addr` is 0 for every operation other than a read.
- R8: Data-register direct (mode 0), address-register direct (mode 1) and quick (mode 12, value taken from `quick_val`) use no microcycles. `done` rises in the first cycle after the start, and the operand is masked to the operand size.
- R9: Immediate (mode 11) performs one prefetch for a byte or word operand and two for a long operand. The operand is `ext0` for byte or word (masked to size) and {`ext0`,`ext1`} for long. The reported effective address is 0.
- R10: `done` pulses in the cycle after the last microcycle, with `ready` high. `ea` and `operand` are valid while `done` is high.
- R11: While the block is busy, `start` and all operation inputs are ignored. The running list, its addresses, the result and the write-back are all unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operand fetch (accepted when ready) |
| mode | input | 4 | Addressing mode code |
| reg_num | input | 3 | Register field of the instruction |
| size | input | 2 | 0 byte, 1 word, 2 long |
| regs | input | 512 | Register file; register i at bits [32i+31:32i], 0–7 data, 8–15 address |
| instr_addr | input | 32 | Address of the current instruction |
| ext0 | input | 16 | First extension word in the prefetch queue |
| ext1 | input | 16 | Second extension word in the prefetch queue |
| quick_val | input | 32 | Value for the quick mode |
| bus_rdata | input | 16 | Read data returned in a read microcycle |
| ready | output | 1 | Block can accept a start |
| bus_op | output | 2 | Current microcycle: 0 none, 1 idle, 2 prefetch, 3 read |
| bus_addr | output | 32 | Read address (0 for other operations) |
| wb_valid | output | 1 | Base-register update valid |
| wb_reg | output | 4 | Register number being updated |
| wb_value | output | 32 | New base-register value |
| done | output | 1 | Operand available |
| ea | output | 32 | Effective address of the finished operation |
| operand | output | 32 | Fetched operand |

## Verification
Most internal faults show up on `bus_op` and `bus_addr` within a cycle or two of the start, because the bench compares every cycle against a behavioural model:
- A wrong slot list or a wrong list index gives an out-of-order idle, prefetch or read, or makes the list end one cycle early or late. The `done` pulse then moves by the same number of cycles.
- A wrong address term shows on `bus_addr` in the first read cycle. Such terms include the index width selection, the sign extension, the PC+2 base and the stack-register byte step.
- A wrong half-word capture shows only on `operand` in the `done` cycle.
- A bad step also shows on `wb_value` in the first cycle.

// File: rtl/eag_pkg.sv
package eag_pkg;

    localparam int WORD_W   = 32;
    localparam int HALF_W   = 16;
    localparam int MAX_UOPS = 4;

    typedef enum logic [3:0] {
        M_DREG    = 4'd0,
        M_AREG    = 4'd1,
        M_IND     = 4'd2,
        M_POSTINC = 4'd3,
        M_PREDEC  = 4'd4,
        M_DISP16  = 4'd5,
        M_INDEX8  = 4'd6,
        M_PCDISP  = 4'd7,
        M_PCINDEX = 4'd8,
        M_ABSW    = 4'd9,
        M_ABSL    = 4'd10,
        M_IMM     = 4'd11,
        M_QUICK   = 4'd12
    } ea_mode_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2
    } op_size_e;

    typedef enum logic [1:0] {
        UOP_NONE = 2'd0,
        UOP_IDLE = 2'd1,
        UOP_PREF = 2'd2,
        UOP_READ = 2'd3
    } uop_e;

endpackage

// File: rtl/eag_addr_calc.sv
module eag_addr_calc
    import eag_pkg::*;
#(
    parameter int XLEN    = WORD_W,
    parameter int REG_CNT = 16,
    localparam int RIDX_W = $clog2(REG_CNT),
    localparam int HALF   = XLEN / 2
) (
    input  ea_mode_e              mode,
    input  logic [2:0]            reg_num,
    input  op_size_e              size,
    input  logic [REG_CNT*XLEN-1:0] regs,
    input  logic [XLEN-1:0]       instr_addr,
    input  logic [HALF-1:0]       ext0,
    input  logic [HALF-1:0]       ext1,
    output logic [XLEN-1:0]       ea,
    output logic                  wb_en,
    output logic [RIDX_W-1:0]     wb_reg,
    output logic [XLEN-1:0]       wb_value
);

    logic [XLEN-1:0] rf [REG_CNT];

    for (genvar g = 0; g < REG_CNT; g++) begin : g_unpack
        assign rf[g] = regs[g*XLEN +: XLEN];
    end

    logic [RIDX_W-1:0] base_idx;
    logic [XLEN-1:0]   base_an;
    logic [XLEN-1:0]   pc_base;
    logic [XLEN-1:0]   idx_raw;
    logic [XLEN-1:0]   idx_val;
    logic [XLEN-1:0]   disp16;
    logic [XLEN-1:0]   disp8;
    logic [XLEN-1:0]   step;

    assign base_idx = {1'b1, reg_num};
    assign base_an  = rf[base_idx];
    assign pc_base  = instr_addr + XLEN'(2);
    assign idx_raw  = rf[ext0[HALF-1 -: RIDX_W]];
    assign idx_val  = ext0[11] ? idx_raw
                               : {{(XLEN-HALF){idx_raw[HALF-1]}}, idx_raw[HALF-1:0]};
    assign disp16   = {{(XLEN-HALF){ext0[HALF-1]}}, ext0};
    assign disp8    = {{(XLEN-8){ext0[7]}}, ext0[7:0]};

    always_comb begin
        unique case (size)
            SZ_LONG: step = XLEN'(4);
            SZ_WORD: step = XLEN'(2);
            default: step = (reg_num == 3'd7) ? XLEN'(2) : XLEN'(1);
        endcase
    end

    always_comb begin
        ea       = '0;
        wb_en    = 1'b0;
        wb_reg   = base_idx;
        wb_value = '0;
        case (mode)
            M_IND:     ea = base_an;
            M_POSTINC: begin
                ea       = base_an;
                wb_en    = 1'b1;
                wb_value = base_an + step;
            end
            M_PREDEC: begin
                ea       = base_an - step;
                wb_en    = 1'b1;
                wb_value = base_an - step;
            end
            M_DISP16:  ea = base_an + disp16;
            M_INDEX8:  ea = base_an + idx_val + disp8;
            M_PCDISP:  ea = pc_base + disp16;
            M_PCINDEX: ea = pc_base + idx_val + disp8;
            M_ABSW:    ea = disp16;
            M_ABSL:    ea = {ext0, ext1};
            default:   ea = '0;
        endcase
    end

endmodule

// File: rtl/eag_seq_plan.sv
module eag_seq_plan
    import eag_pkg::*;
#(
    parameter int SLOTS = MAX_UOPS,
    localparam int CNT_W = $clog2(SLOTS + 1)
) (
    input  ea_mode_e                 mode,
    input  op_size_e                 size,
    output logic [SLOTS-1:0][1:0]    uops,
    output logic [CNT_W-1:0]         n_uops
);

    logic [CNT_W-1:0] n_idle;
    logic [CNT_W-1:0] n_pref;
    logic [CNT_W-1:0] n_read;
    logic [CNT_W-1:0] words;

    assign words = (size == SZ_LONG) ? CNT_W'(2) : CNT_W'(1);

    always_comb begin
        n_idle = '0;
        n_pref = '0;
        n_read = '0;
        case (mode)
            M_IND, M_POSTINC: n_read = words;
            M_PREDEC: begin
                n_idle = CNT_W'(1);
                n_read = words;
            end
            M_DISP16, M_PCDISP, M_ABSW: begin
                n_pref = CNT_W'(1);
                n_read = words;
            end
            M_INDEX8, M_PCINDEX: begin
                n_idle = CNT_W'(1);
                n_pref = CNT_W'(1);
                n_read = words;
            end
            M_ABSL: begin
                n_pref = CNT_W'(2);
                n_read = words;
            end
            M_IMM:   n_pref = words;
            default: ;
        endcase
    end

    assign n_uops = n_idle + n_pref + n_read;

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        always_comb begin
            if (CNT_W'(s) < n_idle)
                uops[s] = UOP_IDLE;
            else if (CNT_W'(s) < n_idle + n_pref)
                uops[s] = UOP_PREF;
            else if (CNT_W'(s) < n_uops)
                uops[s] = UOP_READ;
            else
                uops[s] = UOP_NONE;
        end
    end

endmodule

// File: rtl/ea_operand_unit.sv
module ea_operand_unit
    import eag_pkg::*;
#(
    parameter int XLEN    = WORD_W,
    parameter int REG_CNT = 16,
    parameter int SLOTS   = MAX_UOPS,
    localparam int RIDX_W = $clog2(REG_CNT),
    localparam int HALF   = XLEN / 2,
    localparam int SIDX_W = $clog2(SLOTS),
    localparam int CNT_W  = $clog2(SLOTS + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [3:0]              mode,
    input  logic [2:0]              reg_num,
    input  logic [1:0]              size,
    input  logic [REG_CNT*XLEN-1:0] regs,
    input  logic [XLEN-1:0]         instr_addr,
    input  logic [HALF-1:0]         ext0,
    input  logic [HALF-1:0]         ext1,
    input  logic [XLEN-1:0]         quick_val,
    input  logic [HALF-1:0]         bus_rdata,
    output logic                    ready,
    output logic [1:0]              bus_op,
    output logic [XLEN-1:0]         bus_addr,
    output logic                    wb_valid,
    output logic [RIDX_W-1:0]       wb_reg,
    output logic [XLEN-1:0]         wb_value,
    output logic                    done,
    output logic [XLEN-1:0]         ea,
    output logic [XLEN-1:0]         operand
);

    typedef struct packed {
        logic                  busy;
        logic                  done;
        logic [SLOTS-1:0][1:0] uops;
        logic [SIDX_W-1:0]     idx;
        logic [SIDX_W-1:0]     last;
        logic                  hi_taken;
        op_size_e              size;
        logic [XLEN-1:0]       ea;
        logic [XLEN-1:0]       operand;
        logic                  wb_valid;
        logic [RIDX_W-1:0]     wb_reg;
        logic [XLEN-1:0]       wb_value;
    } ctl_t;

    ctl_t s_d, s_q;

    ea_mode_e mode_in;
    op_size_e size_in;
    assign mode_in = ea_mode_e'(mode);
    assign size_in = op_size_e'(size);

    logic [XLEN-1:0]       calc_ea;
    logic                  calc_wb_en;
    logic [RIDX_W-1:0]     calc_wb_reg;
    logic [XLEN-1:0]       calc_wb_value;
    logic [SLOTS-1:0][1:0] plan_uops;
    logic [CNT_W-1:0]      plan_n;

    eag_addr_calc #(.XLEN(XLEN), .REG_CNT(REG_CNT)) u_calc (
        .mode       (mode_in),
        .reg_num    (reg_num),
        .size       (size_in),
        .regs       (regs),
        .instr_addr (instr_addr),
        .ext0       (ext0),
        .ext1       (ext1),
        .ea         (calc_ea),
        .wb_en      (calc_wb_en),
        .wb_reg     (calc_wb_reg),
        .wb_value   (calc_wb_value)
    );

    eag_seq_plan #(.SLOTS(SLOTS)) u_plan (
        .mode   (mode_in),
        .size   (size_in),
        .uops   (plan_uops),
        .n_uops (plan_n)
    );

    // Operand for forms that need no data read, masked to the operand size.
    logic [XLEN-1:0] raw_val;
    logic [XLEN-1:0] direct_val;

    always_comb begin
        case (mode_in)
            M_DREG:  raw_val = regs[{1'b0, reg_num}*XLEN +: XLEN];
            M_AREG:  raw_val = regs[{1'b1, reg_num}*XLEN +: XLEN];
            M_QUICK: raw_val = quick_val;
            M_IMM:   raw_val = (size_in == SZ_LONG) ? {ext0, ext1}
                                                    : {{(XLEN-HALF){1'b0}}, ext0};
            default: raw_val = '0;
        endcase
        unique case (size_in)
            SZ_BYTE: direct_val = {{(XLEN-8){1'b0}}, raw_val[7:0]};
            SZ_WORD: direct_val = {{(XLEN-HALF){1'b0}}, raw_val[HALF-1:0]};
            default: direct_val = raw_val;
        endcase
    end

    uop_e cur_uop;
    assign cur_uop = s_q.busy ? uop_e'(s_q.uops[s_q.idx]) : UOP_NONE;

    always_comb begin
        s_d          = s_q;
        s_d.done     = 1'b0;
        s_d.wb_valid = 1'b0;
        if (s_q.busy) begin
            if (cur_uop == UOP_READ) begin
                if (s_q.size == SZ_LONG && !s_q.hi_taken) begin
                    s_d.operand[XLEN-1:HALF] = bus_rdata;
                    s_d.hi_taken             = 1'b1;
                end else if (s_q.size == SZ_LONG) begin
                    s_d.operand[HALF-1:0] = bus_rdata;
                end else if (s_q.size == SZ_WORD) begin
                    s_d.operand = {{(XLEN-HALF){1'b0}}, bus_rdata};
                end else begin
                    s_d.operand = {{(XLEN-8){1'b0}}, bus_rdata[7:0]};
                end
            end
            if (s_q.idx == s_q.last) begin
                s_d.busy = 1'b0;
                s_d.done = 1'b1;
            end else begin
                s_d.idx = s_q.idx + SIDX_W'(1);
            end
        end else if (start) begin
            s_d.uops     = plan_uops;
            s_d.idx      = '0;
            s_d.last     = SIDX_W'(plan_n - CNT_W'(1));
            s_d.hi_taken = 1'b0;
            s_d.size     = size_in;
            s_d.ea       = calc_ea;
            s_d.operand  = direct_val;
            s_d.wb_valid = calc_wb_en;
            s_d.wb_reg   = calc_wb_reg;
            s_d.wb_value = calc_wb_value;
            if (plan_n == '0) begin
                s_d.done = 1'b1;
            end else begin
                s_d.busy = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ready    = !s_q.busy;
    assign bus_op   = cur_uop;
    assign bus_addr = (cur_uop == UOP_READ)
                    ? s_q.ea + (s_q.hi_taken ? XLEN'(2) : XLEN'(0)) : '0;
    assign wb_valid = s_q.wb_valid;
    assign wb_reg   = s_q.wb_reg;
    assign wb_value = s_q.wb_value;
    assign done     = s_q.done;
    assign ea       = s_q.ea;
    assign operand  = s_q.operand;

endmodule

// File: rtl/eag_checker.sv
module eag_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic [3:0] mode,
    input logic       ready,
    input logic [1:0] bus_op,
    input logic       wb_valid,
    input logic       done
);

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> bus_op == 2'd0);

    // R6
    busy_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> bus_op != 2'd0);

    // R6
    idle_not_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_op == 2'd1 |=> bus_op != 2'd0);

    // R10
    done_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ready);

    // R8
    direct_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && ready && (mode == 4'd0 || mode == 4'd1 || mode == 4'd12))
        |=> (done && ready));

    // R11
    wb_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && $past(!ready)) |-> !wb_valid);

    // R5
    wb_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> $past(start && ready));

endmodule

bind ea_operand_unit eag_checker u_eag_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .mode     (mode),
    .ready    (ready),
    .bus_op   (bus_op),
    .wb_valid (wb_valid),
    .done     (done)
);

// File: tb/tb_ea_operand_unit.sv
module tb_ea_operand_unit;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [3:0]   mode = '0;
    logic [2:0]   reg_num = '0;
    logic [1:0]   size = '0;
    logic [511:0] regs;
    logic [31:0]  instr_addr = '0;
    logic [15:0]  ext0 = '0;
    logic [15:0]  ext1 = '0;
    logic [31:0]  quick_val = '0;
    logic [15:0]  bus_rdata;
    logic         ready;
    logic [1:0]   bus_op;
    logic [31:0]  bus_addr;
    logic         wb_valid;
    logic [3:0]   wb_reg;
    logic [31:0]  wb_value;
    logic         done;
    logic [31:0]  ea;
    logic [31:0]  operand;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [31:0] rf [16];

    always #5 clk = ~clk;

    always_comb begin
        for (int i = 0; i < 16; i++) regs[i*32 +: 32] = rf[i];
    end

    function automatic logic [15:0] mem16(logic [31:0] a);
        return a[15:0] ^ a[31:16] ^ 16'h3C5A;
    endfunction

    assign bus_rdata = mem16(bus_addr);

    ea_operand_unit dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .reg_num(reg_num),
        .size(size), .regs(regs), .instr_addr(instr_addr), .ext0(ext0), .ext1(ext1),
        .quick_val(quick_val), .bus_rdata(bus_rdata), .ready(ready), .bus_op(bus_op),
        .bus_addr(bus_addr), .wb_valid(wb_valid), .wb_reg(wb_reg), .wb_value(wb_value),
        .done(done), .ea(ea), .operand(operand)
    );

    task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] sx16(logic [15:0] v);
        return {{16{v[15]}}, v};
    endfunction

    function automatic logic [31:0] sx8(logic [7:0] v);
        return {{24{v[7]}}, v};
    endfunction

    function automatic logic [31:0] mask(int sz, logic [31:0] v);
        if (sz == 0) return v & 32'hFF;
        if (sz == 1) return v & 32'hFFFF;
        return v;
    endfunction

    // One operand fetch, compared against a behavioural model every cycle.
    task automatic run(string req, int m, int r, int sz, logic [15:0] e0, logic [15:0] e1,
                       logic [31:0] pc, logic [31:0] qv, bit hold);
        int          ops[$];
        logic [31:0] an, idx, stp, xea, xop, xwb, rd_addr;
        bit          xwb_en, memmode;
        int          nrd, reads_seen;
        an   = rf[8 + r];
        idx  = e0[11] ? rf[e0[15:12]] : sx16(rf[e0[15:12]][15:0]);
        stp  = (sz == 2) ? 4 : (sz == 1) ? 2 : ((r == 7) ? 2 : 1);
        nrd  = (sz == 2) ? 2 : 1;
        xea = 0; xwb_en = 0; xwb = 0; memmode = 1;
        case (m)
            2:  xea = an;
            3:  begin xea = an; xwb_en = 1; xwb = an + stp; end
            4:  begin xea = an - stp; xwb_en = 1; xwb = an - stp; ops.push_back(1); end
            5:  begin xea = an + sx16(e0); ops.push_back(2); end
            6:  begin xea = an + idx + sx8(e0[7:0]); ops.push_back(1); ops.push_back(2); end
            7:  begin xea = pc + 2 + sx16(e0); ops.push_back(2); end
            8:  begin xea = pc + 2 + idx + sx8(e0[7:0]); ops.push_back(1); ops.push_back(2); end
            9:  begin xea = sx16(e0); ops.push_back(2); end
            10: begin xea = {e0, e1}; ops.push_back(2); ops.push_back(2); end
            default: memmode = 0;
        endcase
        if (memmode) begin
            for (int k = 0; k < nrd; k++) ops.push_back(3);
            if (sz == 2) xop = {mem16(xea), mem16(xea + 2)};
            else         xop = mask(sz, {16'h0, mem16(xea)});
        end else begin
            case (m)
                0:  xop = mask(sz, rf[r]);
                1:  xop = mask(sz, rf[8 + r]);
                12: xop = mask(sz, qv);
                default: begin
                    xop = (sz == 2) ? {e0, e1} : mask(sz, {16'h0, e0});
                    ops.push_back(2);
                    if (sz == 2) ops.push_back(2);
                end
            endcase
        end

        mode = 4'(m); reg_num = 3'(r); size = 2'(sz); ext0 = e0; ext1 = e1;
        instr_addr = pc; quick_val = qv; start = 1'b1;
        @(negedge clk);
        if (!hold || ops.size() <= 1) start = 1'b0;
        if (hold) begin
            mode = 4'd4; reg_num = 3'd7; size = 2'd0; ext0 = ~e0; instr_addr = pc ^ 32'h40;
        end
        chk(wb_valid == xwb_en, "R5", "wb_valid", 32'(wb_valid), 32'(xwb_en));
        if (xwb_en) begin
            chk(wb_reg == 4'(8 + r), "R5", "wb_reg", 32'(wb_reg), 32'(8 + r));
            chk(wb_value == xwb, "R5", "wb_value", wb_value, xwb);
        end
        reads_seen = 0;
        for (int j = 0; j < ops.size(); j++) begin
            rd_addr = (ops[j] == 3) ? xea + 32'(2 * reads_seen) : 32'h0;
            chk(bus_op == 2'(ops[j]), "R6", $sformatf("%s op slot %0d", req, j),
                32'(bus_op), 32'(ops[j]));
            chk(bus_addr == rd_addr, (m == 6 || m == 8) ? "R2" : "R7",
                $sformatf("%s addr slot %0d", req, j), bus_addr, rd_addr);
            chk(done == 1'b0 && ready == 1'b0, "R10", "busy during list",
                32'({done, ready}), 32'h0);
            if (j > 0) chk(wb_valid == 1'b0, "R11", "no second write-back",
                           32'(wb_valid), 32'h0);
            if (ops[j] == 3) reads_seen++;
            @(negedge clk);
            if (hold && j >= ops.size() - 2) start = 1'b0;
        end
        chk(done == 1'b1 && ready == 1'b1, "R10", $sformatf("%s done", req),
            32'({done, ready}), 32'h3);
        chk(ea == xea, req, "ea", ea, xea);
        chk(operand == xop, req, "operand", operand, xop);
        chk(bus_op == 2'd0, "R10", "no op after list", 32'(bus_op), 32'h0);
        start = 1'b0;
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) rf[i] = 32'h1000_0000 + 32'(i) * 32'h0101_0110;
        rf[3]  = 32'h0001_FFF0;
        rf[10] = 32'h0002_0000;
        rf[15] = 32'h0000_8000;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(ready == 1'b1 && bus_op == 2'd0, "R1", "reset ready/op", 32'({ready, bus_op}), 32'h4);
        chk(done == 1'b0 && wb_valid == 1'b0, "R1", "reset done/wb", 32'({done, wb_valid}), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ready == 1'b1 && bus_op == 2'd0, "R1", "after release", 32'({ready, bus_op}), 32'h4);

        // R8 direct and quick forms
        run("R8", 0, 3, 1, 16'h0, 16'h0, 32'h0, 32'h0, 0);
        run("R8", 1, 5, 2, 16'h0, 16'h0, 32'h0, 32'h0, 0);
        run("R8", 12, 0, 0, 16'h0, 16'h0, 32'h0, 32'h1234_56F7, 0);
        // R4 R7 plain indirect, long
        run("R7", 2, 2, 2, 16'h0, 16'h0, 32'h0, 32'h0, 0);
        // R5 postincrement byte: step 1, and 2 for register 7; long step 4
        run("R5", 3, 1, 0, 16'h0, 16'h0, 32'h0, 32'h0, 0);
        run("R5", 3, 7, 0, 16'h0, 16'h0, 32'h0, 32'h0, 0);
        run("R5", 3, 4, 2, 16'h0, 16'h0, 32'h0, 32'h0, 0);
        // R5 predecrement word and stack byte
        run("R5", 4, 5, 1, 16'h0, 16'h0, 32'h0, 32'h0, 0);
        run("R5", 4, 7, 0, 16'h0, 16'h0, 32'h0, 32'h0, 0);
        // R4 displacement with negative value
        run("R4", 5, 2, 1, 16'hFF80, 16'h0, 32'h0, 32'h0, 0);
        // R2 indexed: full-width address index, then sign-extended data index
        run("R2", 6, 2, 1, 16'hA8FE, 16'h0, 32'h0, 32'h0, 0);
        run("R2", 6, 2, 2, 16'h3010, 16'h0, 32'h0, 32'h0, 0);
        // R3 PC-relative
        run("R3", 7, 0, 1, 16'h0100, 16'h0, 32'h0000_4000, 32'h0, 0);
        run("R3", 8, 0, 0, 16'h3080, 16'h0, 32'h0000_4000, 32'h0, 0);
        // R4 absolute short (negative) and long
        run("R4", 9, 0, 1, 16'h8004, 16'h0, 32'h0, 32'h0, 0);
        run("R4", 10, 0, 2, 16'h0003, 16'h1230, 32'h0, 32'h0, 0);
        // R9 immediate
        run("R9", 11, 0, 0, 16'hABCD, 16'h0, 32'h0, 32'h0, 0);
        run("R9", 11, 0, 2, 16'hABCD, 16'h1357, 32'h0, 32'h0, 0);
        // R11 start held with changed inputs during a busy indexed long fetch
        run("R11", 6, 2, 2, 16'hA804, 16'h0, 32'h0, 32'h0, 1);
        run("R11", 4, 1, 2, 16'h0, 16'h0, 32'h0, 32'h0, 1);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule